// File: doc/BRIEF.md
# Multi-Channel Display Interrupt Controller

This block is the interrupt register file of a three-channel display compositor. Each channel reports six kinds of event as single-cycle pulses: end of frame, FIFO underflow, early line start, early frame start, end of the configured line, and low buffer. A profiler event pulse comes in as well. The block records each event in a sticky status flag and computes one summary bit per channel from the flags and the per-channel enables. From the summary bits and the profiler flag it drives a single registered interrupt line.

Software reaches the block through a plain synchronous register port with two addresses. Address 0 is the control register and address 1 is the status register. A write takes effect at the clock edge where `reg_wr` is high. A read captures the addressed register into `reg_rdata` at the edge where `reg_rd` is high. Status flags are cleared by writing ones to them. A one written to status bit 0 clears every flag at once. The underflow, end-of-frame and end-of-line enables sit in interleaved control positions. The early-line and early-frame flags count toward the summary with no enable at all.

Top module: `dic_top`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0, and `irq` is 0.
- R2: The writable control bits are 31 (global enable), 15:13 (underflow enable for channel x at 13+x), 12:7 (end-of-frame enable for channel x at 7+2x, end-of-line enable at 8+2x), 3:1 (interrupt generation enable for channel x at 1+x) and 0 (profiler enable). All other control bits read 0, so writing all ones reads back 0x8000FF8F.
- R3: While control bit 31 is 1, an event pulse on channel x sets its sticky status flag at bit 8+8x+e. The event index e is 0 end of frame, 1 underflow, 2 early line, 3 early frame, 4 end of line, 5 low buffer. The flag stays set until it is cleared.
- R4: While control bit 31 is 0, no event pulse and no profiler pulse sets a flag.
- R5: A status write clears each event flag whose bit is 1 in the written data. Flags whose written bit is 0 keep their value.
- R6: An event that arrives in the same cycle as a clear of its flag wins, and the flag stays set. This holds for both the single-flag clear and the clear-all.
- R7: Status bit 0 reads the profiler flag. Writing 1 to status bit 0 clears all event flags and the profiler flag.
- R8: Status bit 1+x reads 1 when channel x has any of these: end of frame with control bit 7+2x set, underflow with 13+x set, end of line with 8+2x set, early line, or early frame. The low-buffer flag never contributes.
- R9: `irq` is a register. Its value is the OR, over x, of (status bit 1+x AND control bit 1+x), ORed with (status bit 0 AND control bit 0), all taken from the previous cycle.
- R10: Status bits 7:4, 15:14, 23:22 and 31:30 always read 0.
- R11: `reg_rdata` changes only on a clock edge where `reg_rd` is 1. Otherwise it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_frame_end | input | 3 | End-of-frame pulse per channel |
| evt_underflow | input | 3 | FIFO underflow pulse per channel |
| evt_line_early | input | 3 | Early line-start pulse per channel |
| evt_frame_early | input | 3 | Early frame-start pulse per channel |
| evt_line_hit | input | 3 | Configured-line-done pulse per channel |
| evt_buf_low | input | 3 | Low-buffer pulse per channel |
| evt_profile | input | 1 | Profiler event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The write-clear property assumes that no event pulse arrives in the cycle of a status write. The bench meets this by driving events and writes in separate cycles, except in the directed race test. The race test is covered instead by the separate property that an event always wins. The properties also assume that every input changes only away from the active edge. The bench drives all inputs on the falling edge.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int NUM_CH      = 3;
  localparam int EV_W        = 6;
  localparam int DW          = 32;
  localparam int STAT_BASE   = 8;
  localparam int STAT_STRIDE = 8;

  localparam int EVI_EOF    = 0;
  localparam int EVI_UFLOW  = 1;
  localparam int EVI_ELINE  = 2;
  localparam int EVI_EFRAME = 3;
  localparam int EVI_EOLN   = 4;
  localparam int EVI_LOWBUF = 5;

  localparam int CB_PROF       = 0;
  localparam int CB_GEN_BASE   = 1;
  localparam int CB_EOF_BASE   = 7;
  localparam int CB_EOLN_BASE  = 8;
  localparam int CB_UFLOW_BASE = 13;
  localparam int CB_GLOBAL     = 31;

  function automatic int stat_pos(int ch, int ev);
    return STAT_BASE + STAT_STRIDE * ch + ev;
  endfunction

  function automatic logic [DW-1:0] ctrl_wmask();
    logic [DW-1:0] m;
    m = '0;
    m[CB_GLOBAL] = 1'b1;
    m[CB_PROF]   = 1'b1;
    for (int c = 0; c < NUM_CH; c++) begin
      m[CB_GEN_BASE + c]     = 1'b1;
      m[CB_EOF_BASE + 2*c]   = 1'b1;
      m[CB_EOLN_BASE + 2*c]  = 1'b1;
      m[CB_UFLOW_BASE + c]   = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] stat_flag_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int e = 0; e < EV_W; e++)
        m[stat_pos(c, e)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dic_ctrl_reg.sv
module dic_ctrl_reg
  import dic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     ctrl,
  output logic              glob_en,
  output logic              prof_en,
  output logic [NUM_CH-1:0] gen_en,
  output logic [NUM_CH-1:0] en_eof,
  output logic [NUM_CH-1:0] en_eoln,
  output logic [NUM_CH-1:0] en_uflow
);
  localparam logic [DW-1:0] WMASK = ctrl_wmask();

  logic [DW-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (wr) ctrl_q <= wdata & WMASK;
  end

  assign ctrl    = ctrl_q;
  assign glob_en = ctrl_q[CB_GLOBAL];
  assign prof_en = ctrl_q[CB_PROF];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    assign gen_en[c]   = ctrl_q[CB_GEN_BASE + c];
    assign en_eof[c]   = ctrl_q[CB_EOF_BASE + 2*c];
    assign en_eoln[c]  = ctrl_q[CB_EOLN_BASE + 2*c];
    assign en_uflow[c] = ctrl_q[CB_UFLOW_BASE + c];
  end
endmodule

// File: rtl/dic_chan_flags.sv
module dic_chan_flags
  import dic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch_en,
  input  logic [EV_W-1:0] ev,
  input  logic [EV_W-1:0] clr,
  input  logic            clr_all,
  input  logic            en_eof,
  input  logic            en_uflow,
  input  logic            en_eoln,
  output logic [EV_W-1:0] flags,
  output logic            summary
);
  logic [EV_W-1:0] flags_q;
  logic [EV_W-1:0] drop;
  logic [EV_W-1:0] arrive;

  assign drop   = clr | {EV_W{clr_all}};
  assign arrive = ev & {EV_W{latch_en}};

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~drop) | arrive;
  end

  assign flags   = flags_q;
  assign summary = (flags_q[EVI_EOF]   & en_eof)
                 | (flags_q[EVI_UFLOW] & en_uflow)
                 | (flags_q[EVI_EOLN]  & en_eoln)
                 | flags_q[EVI_ELINE]
                 | flags_q[EVI_EFRAME];
endmodule

// File: rtl/dic_irq_gen.sv
module dic_irq_gen
  import dic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prof_evt,
  input  logic              latch_en,
  input  logic              clr_all,
  input  logic              prof_en,
  input  logic [NUM_CH-1:0] summary,
  input  logic [NUM_CH-1:0] gen_en,
  output logic              prof_flag,
  output logic              irq
);
  logic prof_q;
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prof_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prof_q <= (prof_q & ~clr_all) | (prof_evt & latch_en);
      irq_q  <= (|(summary & gen_en)) | (prof_q & prof_en);
    end
  end

  assign prof_flag = prof_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dic_top.sv
module dic_top
  import dic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NUM_CH-1:0] evt_frame_end,
  input  logic [NUM_CH-1:0] evt_underflow,
  input  logic [NUM_CH-1:0] evt_line_early,
  input  logic [NUM_CH-1:0] evt_frame_early,
  input  logic [NUM_CH-1:0] evt_line_hit,
  input  logic [NUM_CH-1:0] evt_buf_low,
  input  logic              evt_profile,
  output logic              irq
);
  logic [DW-1:0]     ctrl_q;
  logic              glob_en, prof_en, prof_flag;
  logic [NUM_CH-1:0] gen_en, en_eof, en_eoln, en_uflow, summary;
  logic              wr_ctrl, wr_stat, clr_all;
  logic [DW-1:0]     status_v;
  logic [DW-1:0]     rdata_q;

  assign wr_ctrl = reg_wr & ~reg_addr;
  assign wr_stat = reg_wr &  reg_addr;
  assign clr_all = wr_stat & reg_wdata[0];

  dic_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(reg_wdata),
    .ctrl(ctrl_q), .glob_en(glob_en), .prof_en(prof_en), .gen_en(gen_en),
    .en_eof(en_eof), .en_eoln(en_eoln), .en_uflow(en_uflow)
  );

  logic [EV_W-1:0] ch_flags [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [EV_W-1:0] ev_c;
    logic [EV_W-1:0] clr_c;
    assign ev_c[EVI_EOF]    = evt_frame_end[c];
    assign ev_c[EVI_UFLOW]  = evt_underflow[c];
    assign ev_c[EVI_ELINE]  = evt_line_early[c];
    assign ev_c[EVI_EFRAME] = evt_frame_early[c];
    assign ev_c[EVI_EOLN]   = evt_line_hit[c];
    assign ev_c[EVI_LOWBUF] = evt_buf_low[c];
    assign clr_c = wr_stat ? reg_wdata[stat_pos(c, 0) +: EV_W] : '0;

    dic_chan_flags u_flags (
      .clk(clk), .rst_n(rst_n), .latch_en(glob_en), .ev(ev_c),
      .clr(clr_c), .clr_all(clr_all), .en_eof(en_eof[c]),
      .en_uflow(en_uflow[c]), .en_eoln(en_eoln[c]),
      .flags(ch_flags[c]), .summary(summary[c])
    );
  end

  always_comb begin
    status_v    = '0;
    status_v[0] = prof_flag;
    for (int c = 0; c < NUM_CH; c++) begin
      status_v[CB_GEN_BASE + c]          = summary[c];
      status_v[stat_pos(c, 0) +: EV_W]   = ch_flags[c];
    end
  end

  dic_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .prof_evt(evt_profile), .latch_en(glob_en),
    .clr_all(clr_all), .prof_en(prof_en), .summary(summary),
    .gen_en(gen_en), .prof_flag(prof_flag), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= reg_addr ? status_v : ctrl_q;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/dic_top_chk.sv
module dic_top_chk
  import dic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic [NUM_CH-1:0] evt_frame_end,
  input logic [NUM_CH-1:0] evt_underflow,
  input logic [NUM_CH-1:0] evt_line_early,
  input logic [NUM_CH-1:0] evt_frame_early,
  input logic [NUM_CH-1:0] evt_line_hit,
  input logic [NUM_CH-1:0] evt_buf_low,
  input logic              evt_profile,
  input logic              irq,
  input logic [DW-1:0]     ctrl_q,
  input logic [DW-1:0]     status_v
);
  localparam logic [DW-1:0] WMASK = ctrl_wmask();
  localparam logic [DW-1:0] FMASK = stat_flag_mask();

  logic [DW-1:0] ev_vec;
  logic          irq_src;

  always_comb begin
    ev_vec = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      ev_vec[stat_pos(c, EVI_EOF)]    = evt_frame_end[c];
      ev_vec[stat_pos(c, EVI_UFLOW)]  = evt_underflow[c];
      ev_vec[stat_pos(c, EVI_ELINE)]  = evt_line_early[c];
      ev_vec[stat_pos(c, EVI_EFRAME)] = evt_frame_early[c];
      ev_vec[stat_pos(c, EVI_EOLN)]   = evt_line_hit[c];
      ev_vec[stat_pos(c, EVI_LOWBUF)] = evt_buf_low[c];
    end
    ev_vec[0] = evt_profile;
  end

  assign irq_src = (|(status_v[3:1] & ctrl_q[3:1])) | (status_v[0] & ctrl_q[0]);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(irq_src));

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_GLOBAL] && ev_vec != '0) |=>
      ((status_v & $past(ev_vec)) == $past(ev_vec)));

  // R4
  no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CB_GLOBAL] |=>
      ((status_v & (FMASK | 32'h1) & ~$past(status_v)) == '0));

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && ev_vec == '0) |=>
      ((status_v & $past(reg_wdata & FMASK)) == '0));

  // R2
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_addr) |=> ((reg_rdata & ~WMASK) == '0));

  // R10
  stat_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr) |=> ((reg_rdata & ~(FMASK | 32'hF)) == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind dic_top dic_top_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .evt_frame_end(evt_frame_end), .evt_underflow(evt_underflow),
  .evt_line_early(evt_line_early), .evt_frame_early(evt_frame_early),
  .evt_line_hit(evt_line_hit), .evt_buf_low(evt_buf_low),
  .evt_profile(evt_profile), .irq(irq), .ctrl_q(ctrl_q), .status_v(status_v)
);

// File: tb/tb_dic_top.sv
module tb_dic_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0]  evt_frame_end, evt_underflow, evt_line_early;
  logic [2:0]  evt_frame_early, evt_line_hit, evt_buf_low;
  logic        evt_profile, irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dic_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_frame_end(evt_frame_end), .evt_underflow(evt_underflow),
    .evt_line_early(evt_line_early), .evt_frame_early(evt_frame_early),
    .evt_line_hit(evt_line_hit), .evt_buf_low(evt_buf_low),
    .evt_profile(evt_profile), .irq(irq)
  );

  function automatic int spos(int ch, int ev);
    return 8 + 8 * ch + ev;
  endfunction

  function automatic logic [31:0] sum_bits(logic [31:0] f, logic [31:0] c);
    logic [31:0] s;
    s = '0;
    for (int x = 0; x < 3; x++)
      s[1+x] = (f[spos(x,0)] & c[7+2*x]) | (f[spos(x,1)] & c[13+x]) |
               (f[spos(x,4)] & c[8+2*x]) | f[spos(x,2)] | f[spos(x,3)];
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_evts();
    evt_frame_end = '0; evt_underflow = '0; evt_line_early = '0;
    evt_frame_early = '0; evt_line_hit = '0; evt_buf_low = '0;
    evt_profile = 1'b0;
  endtask

  task automatic set_evt(int ch, int ev);
    case (ev)
      0: evt_frame_end[ch]   = 1'b1;
      1: evt_underflow[ch]   = 1'b1;
      2: evt_line_early[ch]  = 1'b1;
      3: evt_frame_early[ch] = 1'b1;
      4: evt_line_hit[ch]    = 1'b1;
      default: evt_buf_low[ch] = 1'b1;
    endcase
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse(int ch, int ev);
    @(negedge clk); set_evt(ch, ev);
    @(negedge clk); clr_evts();
  endtask

  task automatic pulse_prof();
    @(negedge clk); evt_profile = 1'b1;
    @(negedge clk); evt_profile = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(1'b0, d); check("R1 ctrl", d, 32'h0);
    rd(1'b1, d); check("R1 status", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(1'b0, 32'hFFFF_FFFF); rd(1'b0, d); check("R2 all ones", d, 32'h8000_FF8F);
    wr(1'b0, 32'h0000_0070); rd(1'b0, d); check("R2 bits 6:4", d, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(1'b0, 32'h0);
    pulse(1, 1); pulse(0, 2); pulse_prof();
    rd(1'b1, d); check("R4 no latch", d, 32'h0);
  endtask

  task automatic t_latch();
    logic [31:0] d, f;
    f = '0;
    wr(1'b0, 32'h8000_0000);
    for (int c = 0; c < 3; c++)
      for (int e = 0; e < 6; e++) begin
        pulse(c, e);
        f[spos(c, e)] = 1'b1;
        rd(1'b1, d);
        check($sformatf("R3 ch%0d ev%0d", c, e), d, f | sum_bits(f, 32'h8000_0000));
      end
    check("R10 unused zero", d, 32'h3F3F_3F0E);
    wr(1'b1, 32'h1); rd(1'b1, d); check("R7 clear all", d, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(0, 0); pulse(0, 1);
    wr(1'b1, 32'h1 << 8);  rd(1'b1, d); check("R5 clear one", d, 32'h1 << 9);
    wr(1'b1, 32'h0);       rd(1'b1, d); check("R5 zero keeps", d, 32'h1 << 9);
    wr(1'b1, 32'h1 << 9);  rd(1'b1, d); check("R5 clear other", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    evt_underflow[2] = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h1 << 25;
    @(negedge clk); clr_evts(); reg_wr = 1'b0;
    rd(1'b1, d); check("R6 event beats clear", d, 32'h1 << 25);
    @(negedge clk);
    evt_frame_end[1] = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h1;
    @(negedge clk); clr_evts(); reg_wr = 1'b0;
    rd(1'b1, d); check("R6 event beats clear all", d, 32'h1 << 16);
    wr(1'b1, 32'h1);
  endtask

  task automatic t_summary();
    logic [31:0] d, f;
    wr(1'b0, 32'h8000_0000);
    pulse(1, 5); f = 32'h1 << 21;
    rd(1'b1, d); check("R8 low buffer no summary", d, f);
    pulse(2, 0); f |= 32'h1 << 24;
    rd(1'b1, d); check("R8 eof disabled", d, f);
    wr(1'b0, 32'h8000_0800);
    rd(1'b1, d); check("R8 eof enabled", d, f | 32'h8);
    pulse(0, 4); f |= 32'h1 << 12;
    rd(1'b1, d); check("R8 eoln disabled", d, f | 32'h8);
    wr(1'b0, 32'h8000_0900);
    rd(1'b1, d); check("R8 eoln enabled", d, f | 32'hA);
    wr(1'b1, 32'h1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(1'b0, 32'h8000_4000);
    pulse(1, 1);
    @(negedge clk); @(negedge clk);
    check("R9 gen disabled", {31'b0, irq}, 32'h0);
    wr(1'b1, 32'h1);
    wr(1'b0, 32'h8000_4004);
    check("R9 idle", {31'b0, irq}, 32'h0);
    @(negedge clk); evt_underflow[1] = 1'b1;
    @(negedge clk); clr_evts();
    check("R9 one cycle late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 raised", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h1 << 17);
    check("R9 held after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R9 dropped", {31'b0, irq}, 32'h0);
    wr(1'b0, 32'h8000_0001);
    pulse_prof();
    rd(1'b1, d); check("R7 profiler bit", d, 32'h1);
    check("R9 profiler irq", {31'b0, irq}, 32'h1);
    wr(1'b1, 32'h1);
    rd(1'b1, d); check("R7 profiler cleared", d, 32'h0);
    check("R9 profiler irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    wr(1'b0, 32'h8000_0000);
    rd(1'b0, d); check("R11 read", d, 32'h8000_0000);
    wr(1'b0, 32'h8000_0002);
    @(negedge clk);
    check("R11 hold", reg_rdata, 32'h8000_0000);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    clr_evts();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_disabled();
    t_latch();
    t_w1c();
    t_race();
    t_summary();
    t_irq();
    t_hold();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule